// File: doc/BRIEF.md
# SD Card Clock Generator

This block produces the card clock for an SD/eMMC host. It counts tick pulses from one of two reference sources and divides them by a programmable integer. Each reference tick marks one edge of that reference clock, so a divide value of N gives a card clock period of 2·N ticks with exactly N ticks high and N ticks low. Software programs a clock word and a main word through a single write port. The clock word holds the divider, the source select, three two-bit phase fields and an always-on control. The main word holds a stop control. Setting the stop control holds the card clock off while the divider and source are changed. Clearing it starts the clock again with the new settings.

A four-state machine drives the clock. In `ST_OFF` the stop control is set, the clock is low, and the active divider and source are loaded from the programmed fields every cycle. When stop is cleared, `ST_OFF` moves to `ST_HIGH` if a run is requested and to `ST_PARK` otherwise. A run is requested when the always-on control is set or a transfer is in progress. `ST_PARK` holds the clock low and idle, and moves to `ST_HIGH` when a run is requested. `ST_HIGH` moves to `ST_LOW` after N ticks of the selected source. `ST_LOW` moves, after N ticks, back to `ST_HIGH`, or to `ST_PARK` if no run is requested. Setting the stop control moves any state to `ST_OFF`. A sample strobe marks every rising card edge. In DDR mode it also marks every falling card edge, which gives two data events per card period.

Top module: `sdclk_gen`

## Requirements
- R1: After reset the card clock is low and not running, the strobe is low, the stop control is set, and the phase outputs read output phase 2, transmit phase 0 and receive phase 0.
- R2: With clock word divider field bits 5:0 = N (1..63), the running card clock stays high for exactly N ticks of the selected source and then low for exactly N ticks.
- R3: A divider field value of 0 behaves as a divide value of 1.
- R4: Clock word bit 6 selects the reference source: 0 selects `ref_tick[0]` and 1 selects `ref_tick[1]`. Bit 7 is ignored, and ticks on the unselected source have no effect.
- R5: Clock word bits 9:8, 11:10 and 13:12 appear on `out_phase`, `tx_phase` and `rx_phase` on the cycle after the write, whatever the stop control is.
- R6: Main word bit 0 (stop) forces the card clock low and not running from the cycle after it is registered, and keeps it there for as long as it is set.
- R7: A change to the divider or source written while stop is clear has no effect on the running clock. It takes effect only after stop has been set and cleared again.
- R8: With the always-on control (clock word bit 16) clear and `xfer_active` low, the clock finishes its current low half and then parks low and not running. With the always-on control set, the clock runs with no transfer in progress.
- R9: With the always-on control clear, raising `xfer_active` starts a parked clock with the programmed divider.
- R10: `sample_strobe` pulses for one cycle, together with each rising card edge. When `ddr_mode` is high it also pulses with each falling card edge, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 writes the clock word, 1 writes the main word |
| cfg_wdata | input | 32 | Write data |
| ref_tick | input | 2 | Edge ticks of the two reference clocks |
| ddr_mode | input | 1 | Double data rate mode |
| xfer_active | input | 1 | A transfer is in progress |
| card_clk | output | 1 | Card clock level |
| card_clk_running | output | 1 | Card clock is toggling (high or low half) |
| sample_strobe | output | 1 | One-cycle pulse on each data edge |
| out_phase | output | 2 | Output phase selection |
| tx_phase | output | 2 | Transmit phase selection |
| rx_phase | output | 2 | Receive phase selection |

## Verification
The assertions check these behaviours on every cycle:
- stop forces the clock off on the following cycle;
- the active divider never changes while the clock runs;
- idle gating only ever stops the clock from its low half;
- the strobe matches the rising edges, and in DDR mode the falling edges as well.

Only the bench scenarios can show the exact high and low half lengths for each divider and source, that a divider of zero acts as one, and that bit 7 is ignored. They also show that a divider write while running stays pending until the next stop cycle, and the exact strobe counts over a window in single and double data rate.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

    localparam int DIV_W     = 6;
    localparam int NSRC      = 2;
    localparam int PH_W      = 2;
    localparam int DATA_W    = 32;

    // clock word field positions
    localparam int DIV_LSB   = 0;
    localparam int SRC_LSB   = 6;
    localparam int OPH_LSB   = 8;
    localparam int TPH_LSB   = 10;
    localparam int RPH_LSB   = 12;
    localparam int AON_BIT   = 16;

    // main word field positions
    localparam int STOP_BIT  = 0;

    localparam logic [PH_W-1:0] OPH_RESET = 2'd2;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_PARK = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } clk_state_e;

endpackage

// File: rtl/sdclk_regs.sv
module sdclk_regs
    import sdclk_pkg::*;
#(
    parameter int SRC_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DIV_W-1:0]  div_cfg,
    output logic [SRC_W-1:0]  src_cfg,
    output logic [PH_W-1:0]   oph_cfg,
    output logic [PH_W-1:0]   tph_cfg,
    output logic [PH_W-1:0]   rph_cfg,
    output logic              aon_cfg,
    output logic              stop_cfg
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^{cfg_wdata[DATA_W-1:AON_BIT+1],
                                 cfg_wdata[AON_BIT-1:RPH_LSB+PH_W],
                                 cfg_wdata[OPH_LSB-1:SRC_LSB+SRC_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cfg  <= '0;
            src_cfg  <= '0;
            oph_cfg  <= OPH_RESET;
            tph_cfg  <= '0;
            rph_cfg  <= '0;
            aon_cfg  <= 1'b0;
            stop_cfg <= 1'b1;
        end else if (cfg_wr) begin
            if (!cfg_sel) begin
                div_cfg <= cfg_wdata[DIV_LSB +: DIV_W];
                src_cfg <= cfg_wdata[SRC_LSB +: SRC_W];
                oph_cfg <= cfg_wdata[OPH_LSB +: PH_W];
                tph_cfg <= cfg_wdata[TPH_LSB +: PH_W];
                rph_cfg <= cfg_wdata[RPH_LSB +: PH_W];
                aon_cfg <= cfg_wdata[AON_BIT];
            end else begin
                stop_cfg <= cfg_wdata[STOP_BIT];
            end
        end
    end

endmodule

// File: rtl/sdclk_tick_sel.sv
module sdclk_tick_sel #(
    parameter int NUM_SRC = 2,
    parameter int SRC_W   = 1
) (
    input  logic [NUM_SRC-1:0] ref_tick,
    input  logic [SRC_W-1:0]   src_sel,
    output logic               tick
);

    logic [NUM_SRC-1:0] hit;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign hit[g] = ref_tick[g] && (src_sel == SRC_W'(g));
    end

    assign tick = |hit;

endmodule

// File: rtl/sdclk_fsm.sv
module sdclk_fsm
    import sdclk_pkg::*;
#(
    parameter int SRC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             stop,
    input  logic             aon,
    input  logic             xfer_active,
    input  logic             ddr_mode,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic [SRC_W-1:0] src_cfg,
    output logic [DIV_W-1:0] div_act,
    output logic [SRC_W-1:0] src_act,
    output logic             card_clk,
    output logic             running,
    output logic             strobe
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    clk_state_e       state, nxt;
    logic [DIV_W-1:0] cnt, cnt_nxt;
    logic             load;
    logic             run_req;
    logic             last;
    logic [DIV_W-1:0] div_eff;
    logic             strobe_nxt;

    assign run_req = aon || xfer_active;
    assign last    = (cnt == div_act - ONE);
    assign div_eff = (div_cfg == '0) ? ONE : div_cfg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_OFF;
            cnt     <= '0;
            div_act <= ONE;
            src_act <= '0;
            strobe  <= 1'b0;
        end else begin
            state  <= nxt;
            cnt    <= cnt_nxt;
            strobe <= strobe_nxt;
            if (load) begin
                div_act <= div_eff;
                src_act <= src_cfg;
            end
        end
    end

    // next state
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        load    = 1'b0;
        unique case (state)
            ST_OFF: begin
                load    = 1'b1;
                cnt_nxt = '0;
                if (!stop) nxt = run_req ? ST_HIGH : ST_PARK;
            end
            ST_PARK: begin
                cnt_nxt = '0;
                if (stop)         nxt = ST_OFF;
                else if (run_req) nxt = ST_HIGH;
            end
            ST_HIGH: begin
                if (stop) begin
                    nxt     = ST_OFF;
                    cnt_nxt = '0;
                end else if (tick) begin
                    if (last) begin
                        nxt     = ST_LOW;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + ONE;
                    end
                end
            end
            ST_LOW: begin
                if (stop) begin
                    nxt     = ST_OFF;
                    cnt_nxt = '0;
                end else if (tick) begin
                    if (last) begin
                        nxt     = run_req ? ST_HIGH : ST_PARK;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + ONE;
                    end
                end
            end
            default: begin
                nxt     = ST_OFF;
                cnt_nxt = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        card_clk   = (state == ST_HIGH);
        running    = (state == ST_HIGH) || (state == ST_LOW);
        strobe_nxt = ((nxt == ST_HIGH) && (state != ST_HIGH)) ||
                     (ddr_mode && (state == ST_HIGH) && (nxt == ST_LOW));
    end

endmodule

// File: rtl/sdclk_gen.sv
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int NUM_SRC = NSRC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic                cfg_sel,
    input  logic [DATA_W-1:0]   cfg_wdata,
    input  logic [NUM_SRC-1:0]  ref_tick,
    input  logic                ddr_mode,
    input  logic                xfer_active,
    output logic                card_clk,
    output logic                card_clk_running,
    output logic                sample_strobe,
    output logic [PH_W-1:0]     out_phase,
    output logic [PH_W-1:0]     tx_phase,
    output logic [PH_W-1:0]     rx_phase
);

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [DIV_W-1:0] div_cfg, div_act;
    logic [SRC_W-1:0] src_cfg, src_act;
    logic             aon_cfg;
    logic             stop_q;
    logic             tick;

    sdclk_regs #(.SRC_W(SRC_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .div_cfg   (div_cfg),
        .src_cfg   (src_cfg),
        .oph_cfg   (out_phase),
        .tph_cfg   (tx_phase),
        .rph_cfg   (rx_phase),
        .aon_cfg   (aon_cfg),
        .stop_cfg  (stop_q)
    );

    sdclk_tick_sel #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_tick (
        .ref_tick (ref_tick),
        .src_sel  (src_act),
        .tick     (tick)
    );

    sdclk_fsm #(.SRC_W(SRC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .stop        (stop_q),
        .aon         (aon_cfg),
        .xfer_active (xfer_active),
        .ddr_mode    (ddr_mode),
        .div_cfg     (div_cfg),
        .src_cfg     (src_cfg),
        .div_act     (div_act),
        .src_act     (src_act),
        .card_clk    (card_clk),
        .running     (card_clk_running),
        .strobe      (sample_strobe)
    );

endmodule

// File: rtl/sdclk_gen_chk.sv
module sdclk_gen_chk
    import sdclk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             stop_q,
    input logic             card_clk,
    input logic             card_clk_running,
    input logic             sample_strobe,
    input logic             ddr_mode,
    input logic [DIV_W-1:0] div_act
);

    AST_STOP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |=> (!card_clk && !card_clk_running)); // R6

    AST_DIV_HELD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (card_clk_running && $past(card_clk_running)) |-> $stable(div_act)); // R7

    AST_GATE_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(card_clk_running) && !$past(stop_q)) |-> !$past(card_clk)); // R8

    AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_clk) |-> sample_strobe); // R10

    AST_STROBE_SDR_ONLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_strobe && !$past(ddr_mode)) |-> $rose(card_clk)); // R10

    AST_STROBE_DDR_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(card_clk) && card_clk_running && $past(ddr_mode)) |-> sample_strobe); // R10

endmodule

bind sdclk_gen sdclk_gen_chk u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .stop_q           (stop_q),
    .card_clk         (card_clk),
    .card_clk_running (card_clk_running),
    .sample_strobe    (sample_strobe),
    .ddr_mode         (ddr_mode),
    .div_act          (div_act)
);

// File: tb/sdclk_gen_bench.sv
module sdclk_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  ref_tick = '0;
    logic        ddr_mode = 1'b0;
    logic        xfer_active = 1'b0;
    logic        card_clk, card_clk_running, sample_strobe;
    logic [1:0]  out_phase, tx_phase, rx_phase;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit t0_en = 1'b1;
    bit t1_en = 1'b1;
    int tcnt = 0;

    always #4 clk = ~clk;

    sdclk_gen u_sdclk_gen (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_wr           (cfg_wr),
        .cfg_sel          (cfg_sel),
        .cfg_wdata        (cfg_wdata),
        .ref_tick         (ref_tick),
        .ddr_mode         (ddr_mode),
        .xfer_active      (xfer_active),
        .card_clk         (card_clk),
        .card_clk_running (card_clk_running),
        .sample_strobe    (sample_strobe),
        .out_phase        (out_phase),
        .tx_phase         (tx_phase),
        .rx_phase         (rx_phase)
    );

    // source 0 ticks every cycle, source 1 every third cycle
    initial begin
        forever begin
            @(negedge clk);
            tcnt++;
            ref_tick[0] = t0_en;
            ref_tick[1] = t1_en && (tcnt % 3 == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] clk_word(input int div, input int src,
                                             input int oph, input int tph,
                                             input int rph, input bit aon);
        logic [31:0] w;
        w = '0;
        w[5:0]   = div[5:0];
        w[7:6]   = src[1:0];
        w[9:8]   = oph[1:0];
        w[11:10] = tph[1:0];
        w[13:12] = rph[1:0];
        w[16]    = aon;
        return w;
    endfunction

    task automatic wr(input bit sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic start_clock(input int div, input int src, input bit aon);
        wr(1'b1, 32'h1);
        wr(1'b0, clk_word(div, src, 2, 0, 0, aon));
        wr(1'b1, 32'h0);
    endtask

    task automatic measure(output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        @(negedge clk);
        while (card_clk !== 1'b0 && guard < 300) begin @(negedge clk); guard++; end
        while (card_clk !== 1'b1 && guard < 300) begin @(negedge clk); guard++; end
        while (card_clk === 1'b1 && guard < 300) begin hi++; @(negedge clk); guard++; end
        while (card_clk === 1'b0 && guard < 300) begin lo++; @(negedge clk); guard++; end
        if (guard >= 300) begin hi = -1; lo = -1; end
    endtask

    task automatic run_div(input int div, input int src, input int exp, input string req);
        int hi, lo;
        start_clock(div, src, 1'b1);
        measure(hi, lo);
        chk(hi == exp, req, hi, exp);
        chk(lo == exp, req, lo, exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(card_clk == 1'b0, "R1 clk low", card_clk, 0);
        chk(card_clk_running == 1'b0, "R1 not running", card_clk_running, 0);
        chk(sample_strobe == 1'b0, "R1 strobe", sample_strobe, 0);
        chk(out_phase == 2'd2 && tx_phase == 2'd0 && rx_phase == 2'd0, "R1 phases",
            {out_phase, tx_phase, rx_phase}, 6'b100000);
        repeat (10) @(negedge clk);
        chk(card_clk_running == 1'b0, "R1 stop set at reset", card_clk_running, 0);
    endtask

    task automatic t_divider();
        run_div(3, 0, 3, "R2 div3");
        run_div(1, 0, 1, "R2 div1");
        run_div(5, 0, 5, "R2 div5");
        run_div(0, 0, 1, "R3 div0");
    endtask

    task automatic t_source();
        int hi, lo;
        run_div(2, 1, 6, "R4 src1");
        run_div(2, 2, 2, "R4 bit7 ignored");
        t1_en = 1'b0;
        start_clock(2, 1, 1'b1);
        measure(hi, lo);
        chk(hi == -1, "R4 unselected ticks", hi, -1);
        t1_en = 1'b1;
        t0_en = 1'b1;
    endtask

    task automatic t_phase();
        wr(1'b0, clk_word(2, 0, 1, 3, 2, 1'b1));
        chk(out_phase == 2'd1, "R5 out phase", out_phase, 1);
        chk(tx_phase == 2'd3, "R5 tx phase", tx_phase, 3);
        chk(rx_phase == 2'd2, "R5 rx phase", rx_phase, 2);
    endtask

    task automatic t_stop();
        int bad = 0;
        start_clock(4, 0, 1'b1);
        repeat (5) @(negedge clk);
        wr(1'b1, 32'h1);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (card_clk !== 1'b0 || card_clk_running !== 1'b0) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R6 stop holds off", bad, 0);
    endtask

    task automatic t_pending();
        int hi, lo;
        start_clock(2, 0, 1'b1);
        wr(1'b0, clk_word(5, 0, 2, 0, 0, 1'b1));
        measure(hi, lo);
        chk(hi == 2 && lo == 2, "R7 pending divider", hi, 2);
        wr(1'b1, 32'h1);
        wr(1'b1, 32'h0);
        measure(hi, lo);
        chk(hi == 5 && lo == 5, "R7 applied after stop", hi, 5);
    endtask

    task automatic t_gating();
        int bad = 0;
        int hi, lo;
        xfer_active = 1'b0;
        start_clock(3, 0, 1'b0);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (card_clk !== 1'b0 || card_clk_running !== 1'b0) bad++;
        end
        chk(bad == 0, "R8 parked idle", bad, 0);
        xfer_active = 1'b1;
        measure(hi, lo);
        chk(hi == 3 && lo == 3, "R9 transfer starts clock", hi, 3);
        xfer_active = 1'b0;
        repeat (20) @(negedge clk);
        chk(card_clk_running == 1'b0, "R8 gated after transfer", card_clk_running, 0);
        wr(1'b0, clk_word(3, 0, 2, 0, 0, 1'b1));
        repeat (10) @(negedge clk);
        chk(card_clk_running == 1'b1, "R8 always-on runs", card_clk_running, 1);
    endtask

    task automatic count_strobes(output int n);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sample_strobe === 1'b1) n++;
        end
    endtask

    task automatic t_strobe();
        int n;
        ddr_mode = 1'b0;
        start_clock(2, 0, 1'b1);
        repeat (8) @(negedge clk);
        count_strobes(n);
        chk(n == 10, "R10 sdr strobes", n, 10);
        ddr_mode = 1'b1;
        repeat (8) @(negedge clk);
        count_strobes(n);
        chk(n == 20, "R10 ddr strobes", n, 20);
        ddr_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_divider();
        t_source();
        t_phase();
        t_stop();
        t_pending();
        t_gating();
        t_strobe();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule